// File: doc/BRIEF.md
# DisplayPort Link Rate and Lane Selector

This block picks the cheapest main-link setup for a display mode and produces the clock-recovery ratios that a transcoder needs to carry it. It takes three sink capability bytes (a revision byte, a maximum rate code and a maximum lane byte) and the pixel clock of the mode in kHz. It cleans up the capability bytes and flags modes that are too fast for the sink or too slow to be legal. It then searches for the narrowest, slowest link that carries three bytes per pixel.

A one-cycle `start` pulse launches a selection. When a link fits, the block loads two ratio pairs into shifting reducers. The data pair is (pixel × 3, link clock × lanes) and the link pair is (pixel, link clock). Each reducer shifts its pair right, one step per clock, until both terms fit the output width. A one-cycle `done` pulse then marks the results valid. The transfer-unit size travels with the data M value as a field above it. When no link fits, the previous selection and ratios stay in place and a no-fit flag is raised.

Top module: `dp_link_select`

## Requirements
- R1: The maximum lane count is 4 when `cap_rev` is below 0x11. Otherwise it is `cap_lanes[4:0]` when that value is 1, 2 or 4, and 4 for any other value.
- R2: The maximum rate is high only when `cap_rate` equals 0x0A. Every other code counts as the low rate 0x06. `rate_code` only ever shows 0x06 or 0x0A. `link_khz` is 162000 for 0x06 and 270000 for 0x0A.
- R3: The selection tries lane counts 1, 2, 4 in that order, and within each lane count tries the low rate before the high rate. It takes the first pair, within the maxima, whose link clock × lanes is at least pixel × 3. `lane_cnt` carries the lane count as the plain binary values 1, 2 or 4.
- R4: `too_fast` is set when pixel × 3 exceeds the maximum link clock × the maximum lane count. In that case `no_fit` is also set, and the previous rate, lane count, link clock and ratios are kept.
- R5: `too_slow` is set when the pixel clock is below 10000 kHz. A selection is still made.
- R6: Data M starts as pixel × 3 and data N as link clock × lanes. Link M starts as the pixel clock and link N as the link clock. Each pair is shifted right by one, both terms together, for as long as either term is 2^FIT_W or more.
- R7: `data_m_word` holds TU_SIZE − 1 (63) in its upper TU_W bits and data M in its lower FIT_W bits.
- R8: `done` pulses for exactly one cycle for each accepted `start`. `busy` is high while the reducers are working. A `start` that arrives while `busy` is high is ignored.
- R9: After reset the outputs are: rate 0x06, one lane, link clock 162000, all flags low, `busy` and `done` low, and all M/N values zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a selection (accepted when idle) |
| cap_rev | input | 8 | Sink capability revision byte |
| cap_rate | input | 8 | Sink maximum rate code |
| cap_lanes | input | 8 | Sink maximum lane byte |
| pix_khz | input | PIX_W | Mode pixel clock in kHz |
| busy | output | 1 | Ratio reduction in progress |
| done | output | 1 | One-cycle result-valid pulse |
| rate_code | output | 8 | Selected rate code |
| lane_cnt | output | 3 | Selected lane count (1, 2 or 4) |
| link_khz | output | 19 | Link clock of the selected rate in kHz |
| too_fast | output | 1 | Mode exceeds the sink's maximum link |
| too_slow | output | 1 | Pixel clock below 10000 kHz |
| no_fit | output | 1 | No link covers the mode; selection kept |
| data_m_word | output | TU_W+FIT_W | Transfer-unit field above data M |
| data_n | output | FIT_W | Reduced data N |
| link_m | output | FIT_W | Reduced link M |
| link_n | output | FIT_W | Reduced link N |

## Verification
The bench drives two instances from the same stimulus. The first uses the default FIT_W of 24, so the reducer is built as its pass-through variant, because real kHz products never reach 24 bits. The second uses FIT_W of 16, which builds the shifting reducer. There, high lane counts and fast modes need several shift steps, which brings multi-cycle reduction and the ignored start during `busy` within reach. Random capability bytes, including out-of-range lane and rate values, and pixel clocks on both sides of the 10000 kHz and maximum-bandwidth limits, are mixed with directed cases at the exact bandwidth boundaries.

// File: rtl/dp_link_pkg.sv
package dp_link_pkg;
   localparam logic [7:0] RATE_CODE_LO   = 8'h06;
   localparam logic [7:0] RATE_CODE_HI   = 8'h0A;
   localparam logic [7:0] REV_LANE_FIELD = 8'h11;
   localparam int         LINK_KHZ_W     = 19;
   localparam logic [LINK_KHZ_W-1:0] LINK_KHZ_LO = 19'd162000;
   localparam logic [LINK_KHZ_W-1:0] LINK_KHZ_HI = 19'd270000;
   localparam int         CAP_W          = 21;   // width of 4 lanes at the high rate
   localparam int         CAND_N         = 6;    // 3 lane counts x 2 rates

   typedef enum logic {
      PH_IDLE,
      PH_SHRINK
   } phase_t;

   function automatic logic [LINK_KHZ_W-1:0] rate_khz(input logic hi);
      return hi ? LINK_KHZ_HI : LINK_KHZ_LO;
   endfunction
endpackage

// File: rtl/dp_cap_decode.sv
module dp_cap_decode
   import dp_link_pkg::*;
(
   input  logic [7:0] cap_rev,
   input  logic [7:0] cap_rate,
   input  logic [7:0] cap_lanes,
   output logic [2:0] max_lanes,
   output logic       max_hi
);
   logic [4:0] lane_field;
   logic [2:0] unused_lane_bits;

   assign lane_field       = cap_lanes[4:0];
   assign unused_lane_bits = cap_lanes[7:5];

   always_comb begin
      max_lanes = 3'd4;
      if (cap_rev >= REV_LANE_FIELD) begin
         case (lane_field)
            5'd1:    max_lanes = 3'd1;
            5'd2:    max_lanes = 3'd2;
            default: max_lanes = 3'd4;
         endcase
      end
   end

   assign max_hi = (cap_rate == RATE_CODE_HI);
endmodule

// File: rtl/dp_link_search.sv
module dp_link_search
   import dp_link_pkg::*;
#(
   parameter int REQ_W = 22
) (
   input  logic [REQ_W-1:0]      req,
   input  logic [2:0]            max_lanes,
   input  logic                  max_hi,
   output logic                  hit,
   output logic                  sel_hi,
   output logic [2:0]            sel_lanes,
   output logic [LINK_KHZ_W-1:0] sel_khz
);
   logic [CAND_N-1:0] hit_vec;
   logic [2:0]        pick;

   // Candidate c: lanes = 1 << (c/2), rate high when c is odd.
   // Lower index means cheaper link, so the lowest hit wins.
   for (genvar c = 0; c < CAND_N; c++) begin : g_cand
      localparam int  LN = 1 << (c / 2);
      localparam bit  HI = (c % 2) == 1;
      logic [REQ_W-1:0] cap;
      logic             allowed;
      assign cap     = REQ_W'(rate_khz(HI)) * REQ_W'(LN);
      assign allowed = (3'(LN) <= max_lanes) && (!HI || max_hi);
      assign hit_vec[c] = allowed && (cap >= req);
   end

   always_comb begin
      pick = 3'd0;
      for (int c = CAND_N - 1; c >= 0; c--) begin
         if (hit_vec[c]) pick = 3'(c);
      end
   end

   assign hit       = |hit_vec;
   assign sel_hi    = pick[0];
   assign sel_lanes = 3'(3'd1 << pick[2:1]);
   assign sel_khz   = rate_khz(sel_hi);
endmodule

// File: rtl/dp_ratio_shrink.sv
module dp_ratio_shrink #(
   parameter int IN_W  = 22,
   parameter int OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IN_W-1:0]  m_in,
   input  logic [IN_W-1:0]  n_in,
   output logic [OUT_W-1:0] m_out,
   output logic [OUT_W-1:0] n_out,
   output logic             fits
);
   logic [IN_W-1:0] m_q;
   logic [IN_W-1:0] n_q;

   if (OUT_W >= IN_W) begin : g_pass
      // Inputs can never exceed the output range: no shifter needed.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= '0;
            n_q <= '0;
         end else if (load) begin
            m_q <= m_in;
            n_q <= n_in;
         end
      end
      assign m_out = OUT_W'(m_q);
      assign n_out = OUT_W'(n_q);
      assign fits  = 1'b1;
   end else begin : g_shift
      logic wide;
      assign wide = (|m_q[IN_W-1:OUT_W]) || (|n_q[IN_W-1:OUT_W]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= '0;
            n_q <= '0;
         end else if (load) begin
            m_q <= m_in;
            n_q <= n_in;
         end else if (wide) begin
            m_q <= m_q >> 1;
            n_q <= n_q >> 1;
         end
      end
      assign m_out = m_q[OUT_W-1:0];
      assign n_out = n_q[OUT_W-1:0];
      assign fits  = !wide;
   end
endmodule

// File: rtl/dp_link_select.sv
module dp_link_select
   import dp_link_pkg::*;
#(
   parameter int PIX_W       = 20,
   parameter int FIT_W       = 24,
   parameter int BPP         = 3,
   parameter int TU_SIZE     = 64,
   parameter int TU_W        = 6,
   parameter int MIN_PIX_KHZ = 10000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [7:0]            cap_rev,
   input  logic [7:0]            cap_rate,
   input  logic [7:0]            cap_lanes,
   input  logic [PIX_W-1:0]      pix_khz,
   output logic                  busy,
   output logic                  done,
   output logic [7:0]            rate_code,
   output logic [2:0]            lane_cnt,
   output logic [LINK_KHZ_W-1:0] link_khz,
   output logic                  too_fast,
   output logic                  too_slow,
   output logic                  no_fit,
   output logic [TU_W+FIT_W-1:0] data_m_word,
   output logic [FIT_W-1:0]      data_n,
   output logic [FIT_W-1:0]      link_m,
   output logic [FIT_W-1:0]      link_n
);
   localparam int REQ_W  = PIX_W + 2;
   localparam int CALC_W = (REQ_W > CAP_W) ? REQ_W : CAP_W;
   localparam logic [TU_W-1:0] TU_FIELD = TU_W'(TU_SIZE - 1);

   if (PIX_W < 14)                 begin : g_bad_pix $error("PIX_W too small"); end
   if (BPP < 1 || BPP > 4)         begin : g_bad_bpp $error("BPP out of range"); end
   if (FIT_W < 8)                  begin : g_bad_fit $error("FIT_W too small"); end
   if (TU_SIZE < 1 || TU_SIZE > (1 << TU_W)) begin : g_bad_tu $error("TU_SIZE does not fit TU_W"); end

   // capability clean-up
   logic [2:0] max_lanes;
   logic       max_hi;

   dp_cap_decode u_cap (
      .cap_rev   (cap_rev),
      .cap_rate  (cap_rate),
      .cap_lanes (cap_lanes),
      .max_lanes (max_lanes),
      .max_hi    (max_hi)
   );

   // bandwidth need and mode limits
   logic [CALC_W-1:0] req;
   logic [CALC_W-1:0] max_cap;
   logic              fast_c;
   logic              slow_c;

   assign req     = CALC_W'(pix_khz) * CALC_W'(BPP);
   assign max_cap = CALC_W'(rate_khz(max_hi)) * CALC_W'(max_lanes);
   assign fast_c  = req > max_cap;
   assign slow_c  = CALC_W'(pix_khz) < CALC_W'(MIN_PIX_KHZ);

   // cheapest link search
   logic                  hit;
   logic                  sel_hi;
   logic [2:0]            sel_lanes;
   logic [LINK_KHZ_W-1:0] sel_khz;

   dp_link_search #(.REQ_W(CALC_W)) u_search (
      .req       (req),
      .max_lanes (max_lanes),
      .max_hi    (max_hi),
      .hit       (hit),
      .sel_hi    (sel_hi),
      .sel_lanes (sel_lanes),
      .sel_khz   (sel_khz)
   );

   // control
   phase_t phase_q;
   logic   accept;
   logic   load;
   logic   fits_data;
   logic   fits_link;

   assign accept = start && (phase_q == PH_IDLE);
   assign load   = accept && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         done      <= 1'b0;
         rate_code <= RATE_CODE_LO;
         lane_cnt  <= 3'd1;
         link_khz  <= LINK_KHZ_LO;
         too_fast  <= 1'b0;
         too_slow  <= 1'b0;
         no_fit    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  too_fast <= fast_c;
                  too_slow <= slow_c;
                  no_fit   <= !hit;
                  if (hit) begin
                     rate_code <= sel_hi ? RATE_CODE_HI : RATE_CODE_LO;
                     lane_cnt  <= sel_lanes;
                     link_khz  <= sel_khz;
                     phase_q   <= PH_SHRINK;
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            PH_SHRINK: begin
               if (fits_data && fits_link) begin
                  done    <= 1'b1;
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase_q == PH_SHRINK);

   // ratio reducers
   logic [CALC_W-1:0] dm_in;
   logic [CALC_W-1:0] dn_in;
   logic [CALC_W-1:0] lm_in;
   logic [CALC_W-1:0] ln_in;
   logic [FIT_W-1:0]  data_m;

   assign dm_in = req;
   assign dn_in = CALC_W'(sel_khz) * CALC_W'(sel_lanes);
   assign lm_in = CALC_W'(pix_khz);
   assign ln_in = CALC_W'(sel_khz);

   dp_ratio_shrink #(.IN_W(CALC_W), .OUT_W(FIT_W)) u_data_ratio (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .m_in  (dm_in),
      .n_in  (dn_in),
      .m_out (data_m),
      .n_out (data_n),
      .fits  (fits_data)
   );

   dp_ratio_shrink #(.IN_W(CALC_W), .OUT_W(FIT_W)) u_link_ratio (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .m_in  (lm_in),
      .n_in  (ln_in),
      .m_out (link_m),
      .n_out (link_n),
      .fits  (fits_link)
   );

   assign data_m_word = {TU_FIELD, data_m};
endmodule

// File: rtl/dp_link_select_chk.sv
module dp_link_select_chk
   import dp_link_pkg::*;
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  busy,
   input logic                  done,
   input logic [7:0]            rate_code,
   input logic [2:0]            lane_cnt,
   input logic [LINK_KHZ_W-1:0] link_khz,
   input logic                  too_fast,
   input logic                  no_fit
);
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy || done));

   a_r4_fast_nofit: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (too_fast == no_fit));

   a_r4_keep_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (done && no_fit) |-> (rate_code == $past(rate_code) && lane_cnt == $past(lane_cnt)));

   a_r2_rate_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_code == RATE_CODE_LO) || (rate_code == RATE_CODE_HI));

   a_r2_khz_match: assert property (@(posedge clk) disable iff (!rst_n)
      link_khz == ((rate_code == RATE_CODE_HI) ? LINK_KHZ_HI : LINK_KHZ_LO));

   a_r3_lanes_legal: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lane_cnt) == 1);
endmodule

bind dp_link_select dp_link_select_chk u_chk (.*);

// File: tb/tb_dp_link_select.sv
`timescale 1ns/1ps
module tb_dp_link_select;
   localparam int PIX_W  = 20;
   localparam int FIT_A  = 24;
   localparam int FIT_B  = 16;
   localparam int TU_W   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [7:0] cap_rev = 8'h11, cap_rate = 8'h0A, cap_lanes = 8'h04;
   logic [PIX_W-1:0] pix_khz = '0;

   always #2.5 clk = ~clk;

   logic busy_a, done_a, fast_a, slow_a, nofit_a;
   logic [7:0] rate_a; logic [2:0] lanes_a; logic [18:0] khz_a;
   logic [TU_W+FIT_A-1:0] dmw_a; logic [FIT_A-1:0] dn_a, lm_a, ln_a;
   logic busy_b, done_b, fast_b, slow_b, nofit_b;
   logic [7:0] rate_b; logic [2:0] lanes_b; logic [18:0] khz_b;
   logic [TU_W+FIT_B-1:0] dmw_b; logic [FIT_B-1:0] dn_b, lm_b, ln_b;

   dp_link_select #(.PIX_W(PIX_W), .FIT_W(FIT_A)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cap_rev(cap_rev), .cap_rate(cap_rate),
      .cap_lanes(cap_lanes), .pix_khz(pix_khz), .busy(busy_a), .done(done_a),
      .rate_code(rate_a), .lane_cnt(lanes_a), .link_khz(khz_a), .too_fast(fast_a),
      .too_slow(slow_a), .no_fit(nofit_a), .data_m_word(dmw_a), .data_n(dn_a),
      .link_m(lm_a), .link_n(ln_a));

   dp_link_select #(.PIX_W(PIX_W), .FIT_W(FIT_B)) dut_narrow (
      .clk(clk), .rst_n(rst_n), .start(start), .cap_rev(cap_rev), .cap_rate(cap_rate),
      .cap_lanes(cap_lanes), .pix_khz(pix_khz), .busy(busy_b), .done(done_b),
      .rate_code(rate_b), .lane_cnt(lanes_b), .link_khz(khz_b), .too_fast(fast_b),
      .too_slow(slow_b), .no_fit(nofit_b), .data_m_word(dmw_b), .data_n(dn_b),
      .link_m(lm_b), .link_n(ln_b));

   int checks = 0;
   int errors = 0;

   // expected state (selection is shared, ratios per instance)
   longint e_rate = 6, e_lanes = 1, e_khz = 162000;
   bit     e_fast = 0, e_slow = 0, e_nofit = 0;
   longint e_dm_a = 0, e_dn_a = 0, e_lm_a = 0, e_ln_a = 0;
   longint e_dm_b = 0, e_dn_b = 0, e_lm_b = 0, e_ln_b = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint max_lanes_of(input longint rev, input longint lb);
      longint v;
      if (rev < 'h11) return 4;
      v = lb & 'h1f;
      if (v == 1 || v == 2 || v == 4) return v;
      return 4;
   endfunction

   task automatic reduce(input int fw, inout longint m, inout longint n);
      longint lim = longint'(1) << fw;
      while (m >= lim || n >= lim) begin
         m = m >> 1;
         n = n >> 1;
      end
   endtask

   task automatic predict(input longint rev, input longint rt, input longint lb, input longint pix);
      longint ml = max_lanes_of(rev, lb);
      bit     mh = (rt == 'h0A);
      longint need = pix * 3;
      longint maxcap = (mh ? 270000 : 162000) * ml;
      bit     found = 0;
      longint fl = 0, fk = 0;
      bit     fh = 0;
      for (int li = 0; li < 3; li++) begin
         longint l = longint'(1) << li;
         for (int h = 0; h < 2; h++) begin
            longint k = (h == 1) ? 270000 : 162000;
            if (!found && l <= ml && (h == 0 || mh) && k * l >= need) begin
               found = 1; fl = l; fk = k; fh = (h == 1);
            end
         end
      end
      e_fast  = (need > maxcap);
      e_slow  = (pix < 10000);
      e_nofit = !found;
      if (found) begin
         longint m, n;
         e_rate = fh ? 'h0A : 'h06; e_lanes = fl; e_khz = fk;
         m = need; n = fk * fl; reduce(FIT_A, m, n); e_dm_a = m; e_dn_a = n;
         m = need; n = fk * fl; reduce(FIT_B, m, n); e_dm_b = m; e_dn_b = n;
         m = pix;  n = fk;      reduce(FIT_A, m, n); e_lm_a = m; e_ln_a = n;
         m = pix;  n = fk;      reduce(FIT_B, m, n); e_lm_b = m; e_ln_b = n;
      end
   endtask

   task automatic compare_all(input string tag);
      chk(rate_a == e_rate && rate_b == e_rate, "R2", {tag, " rate"}, rate_a, e_rate);
      chk(khz_a == e_khz && khz_b == e_khz, "R2", {tag, " link_khz"}, khz_a, e_khz);
      chk(lanes_a == e_lanes && lanes_b == e_lanes, "R3", {tag, " lanes"}, lanes_a, e_lanes);
      chk(fast_a == e_fast && nofit_a == e_nofit && fast_b == e_fast && nofit_b == e_nofit,
          "R4", {tag, " fast/nofit"}, {fast_a, nofit_a}, {e_fast, e_nofit});
      chk(slow_a == e_slow && slow_b == e_slow, "R5", {tag, " too_slow"}, slow_a, e_slow);
      chk(dmw_a[FIT_A-1:0] == e_dm_a && dn_a == e_dn_a, "R6", {tag, " data ratio w24"},
          dn_a, e_dn_a);
      chk(lm_a == e_lm_a && ln_a == e_ln_a, "R6", {tag, " link ratio w24"}, lm_a, e_lm_a);
      chk(dmw_b[FIT_B-1:0] == e_dm_b && dn_b == e_dn_b, "R6", {tag, " data ratio w16"},
          dn_b, e_dn_b);
      chk(lm_b == e_lm_b && ln_b == e_ln_b, "R6", {tag, " link ratio w16"}, ln_b, e_ln_b);
      chk(dmw_a[TU_W+FIT_A-1:FIT_A] == 63 && dmw_b[TU_W+FIT_B-1:FIT_B] == 63, "R7",
          {tag, " tu field"}, dmw_a[TU_W+FIT_A-1:FIT_A], 63);
   endtask

   // waits after the start edge until both instances pulsed done
   task automatic wait_done(input string tag);
      bit sa = 0, sb = 0;
      for (int k = 0; k < 200; k++) begin
         if (done_a) sa = 1;
         if (done_b) sb = 1;
         if (sa && sb) break;
         @(negedge clk);
      end
      chk(sa && sb, "R8", {tag, " done seen"}, {sa, sb}, 3);
      compare_all(tag);
      @(negedge clk);
      chk(!done_a && !done_b, "R8", {tag, " done single pulse"}, {done_a, done_b}, 0);
   endtask

   task automatic run(input logic [7:0] rev, input logic [7:0] rt, input logic [7:0] lb,
                      input longint pix, input string tag);
      @(negedge clk);
      cap_rev = rev; cap_rate = rt; cap_lanes = lb; pix_khz = PIX_W'(pix);
      predict(rev, rt, lb, pix);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(rate_a == 8'h06 && lanes_a == 3'd1 && khz_a == 19'd162000, "R9", "reset selection",
          rate_a, 6);
      chk(!busy_a && !done_a && !fast_a && !slow_a && !nofit_a && !busy_b && !done_b, "R9",
          "reset flags", {busy_a, done_a, fast_a, slow_a, nofit_a}, 0);
      chk(dn_a == 0 && lm_a == 0 && ln_a == 0 && dmw_a[FIT_A-1:0] == 0, "R9", "reset ratios",
          dn_a, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corner cases
      run(8'h11, 8'h0A, 8'h04, 54000, "R3 1lane low exact");      // 162000 exactly
      run(8'h11, 8'h0A, 8'h04, 54001, "R3 1lane high");
      run(8'h11, 8'h0A, 8'h04, 90001, "R3 2lane low");
      run(8'h11, 8'h0A, 8'h04, 360000, "R3 4lane high exact");
      run(8'h11, 8'h0A, 8'h04, 360001, "R4 over max");
      run(8'h10, 8'h06, 8'h01, 216000, "R1 old rev ignores lane byte");
      run(8'h11, 8'h06, 8'h02, 108001, "R1 two-lane cap");
      run(8'h11, 8'h07, 8'h03, 216001, "R2 bad rate code falls low");
      run(8'h12, 8'h0A, 8'hE1, 90000, "R1 upper lane bits masked");
      run(8'h11, 8'h0A, 8'h04, 9999, "R5 below min");
      run(8'h11, 8'h0A, 8'h04, 10000, "R5 at min");
      run(8'h11, 8'h0A, 8'h04, 0, "R5 zero pixel");

      // R8: start while busy is ignored (narrow instance needs several shifts)
      @(negedge clk);
      cap_rev = 8'h11; cap_rate = 8'h0A; cap_lanes = 8'h04; pix_khz = PIX_W'(300000);
      predict(8'h11, 8'h0A, 8'h04, 300000);
      start = 1'b1;
      @(negedge clk);
      chk(busy_a && busy_b, "R8", "busy after accept", {busy_a, busy_b}, 3);
      pix_khz = PIX_W'(5000);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy_b, "R8", "narrow still busy", busy_b, 1);
      wait_done("R8 start during busy");
      begin
         bit extra = 0;
         for (int k = 0; k < 20; k++) begin
            if (done_a || done_b) extra = 1;
            @(negedge clk);
         end
         chk(!extra, "R8", "no second result", extra, 0);
      end

      // constrained random
      for (int t = 0; t < 300; t++) begin
         logic [7:0] rv, rr, rl;
         longint px;
         int unsigned sel;
         sel = $urandom % 4;
         rv = (sel == 0) ? 8'h10 : (sel == 1) ? 8'h11 : (sel == 2) ? 8'h14 : 8'($urandom);
         sel = $urandom % 3;
         rr = (sel == 0) ? 8'h06 : (sel == 1) ? 8'h0A : 8'($urandom);
         sel = $urandom % 3;
         rl = (sel == 0) ? 8'({$urandom % 3} == 0 ? 1 : ($urandom % 2 ? 2 : 4)) : 8'($urandom);
         sel = $urandom % 4;
         px = (sel == 0) ? longint'($urandom % 12000) :
              (sel == 3) ? longint'($urandom % (1 << PIX_W)) :
                           longint'($urandom % 400000);
         run(rv, rr, rl, px, "R3 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule